// File: doc/BRIEF.md
# Configurable GPIO Pin Controller

This block runs one general-purpose pin. Software writes a 16-bit configuration word and a single level bit through a plain register write port. The configuration selects the pin's direction, its pull resistor, its polarity, push-pull or open-drain drive, a master enable, and how interrupts are raised. On the pad side, the block drives an output value, an output enable and two pull enables. It reads the pad through a two-flop synchronizer followed by a de-bounce filter. A sticky interrupt flag records the chosen edges of the filtered level.

The readback level is the filtered pad level, inverted when the polarity bit selects active-low. A separate valid output tells the reader whether the level means anything in the current mode. When it does not, the level reads as 0. All ports are control or status pins with no streaming data, so the block has no valid/ready handshake and never applies back-pressure. Up to twelve copies can sit side by side, one per pin.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset the configuration reads 16'hA400 (input, pull-down, active-high, push-pull, disabled, function 0). In this state pad_oe=0, pad_pd=1, pad_pu=0, irq=0, lvl_rd_valid=0 and lvl_rd=0.
- R2: A write with wr_sel=0 stores all 16 bits of wr_data, and cfg_rd returns them unchanged. A write with wr_sel=1 stores only wr_data[0] as the level bit. Field positions: enable is bit 7, polarity is bit 10 (1 = active-high), direction is bit 15 (1 = input), the pull field is bits 14:13, interrupt mode is bit 12, open-drain is bit 9, and the function is bits 3:0. Bit 11 and the remaining bits are only stored.
- R3: Pull field 01 raises pad_pd only, 10 raises pad_pu only, and 00 and 11 raise neither. pad_pu and pad_pd are never high together.
- R4: The pad is driven only when enable=1, function=0 and direction=0. In push-pull mode pad_oe=1 and pad_out equals the level bit, inverted when polarity=0.
- R5: In open-drain mode pad_out is always 0. pad_oe is high exactly when the wanted pad level is low.
- R6: With enable=0, pad_oe=0 and lvl_rd_valid=0.
- R7: After synchronization, a new pad level must hold for DEB_CYCLES consecutive cycles before the filtered level takes it. A pulse shorter than that leaves the filtered level, lvl_rd and irq unchanged.
- R8: lvl_rd is the filtered pad level XOR (polarity==0). lvl_rd_valid = enable AND NOT (direction=output AND open-drain AND pull≠10). When lvl_rd_valid is 0, lvl_rd is 0.
- R9: Interrupt edges are taken on the filtered level, and only while enable=1. With mode 0, a rising pad edge raises irq when polarity=1 and a falling pad edge raises it when polarity=0. With mode 1, both edges raise irq.
- R10: irq stays high until irq_clr is asserted for a cycle. An edge that arrives in the same cycle as the clear wins, and irq stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = configuration word, 1 = level bit |
| wr_data | input | 16 | Write data |
| cfg_rd | output | 16 | Current configuration word |
| lvl_rd | output | 1 | Polarity-adjusted filtered pad level |
| lvl_rd_valid | output | 1 | High when lvl_rd is meaningful |
| pad_in | input | 1 | Pad level seen from outside |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| irq | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clear the interrupt flag |

## Verification
The bench builds the block with DEB_CYCLES=5. This keeps each filter window short, so one run can cover a pulse one cycle too short, a level held just long enough, and a clear landing on the exact cycle an edge is registered. The bench models the pad wire itself: the driven value when pad_oe is high, otherwise the pull, otherwise an external level. This lets output-mode readback travel the real loop through the synchronizer and filter.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;

  typedef struct packed {
    logic       dir_in;
    pull_e      pull;
    logic       irq_both;
    logic       pwr_dom;
    logic       act_high;
    logic       open_drain;
    logic       spare8;
    logic       enable;
    logic [2:0] spare_mid;
    logic [3:0] func;
  } pin_cfg_t;

  localparam logic [15:0] CFG_RESET = 16'hA400;
  localparam logic [3:0]  FUNC_GPIO = 4'h0;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (raw == level) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      level <= raw;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic arm,
  input  logic both,
  input  logic act_high,
  input  logic clr,
  output logic flag
);
  logic prev;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
  assign hit  = arm & (both ? (rise | fall) : (act_high ? rise : fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pkg::*;
#(
  parameter int DEB_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] cfg_rd,
  output logic        lvl_rd,
  output logic        lvl_rd_valid,
  input  logic        pad_in,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        pad_pu,
  output logic        pad_pd,
  output logic        irq,
  input  logic        irq_clr
);
  logic [15:0] cfg_q;
  logic        lvl_q;
  pin_cfg_t    cfg;
  logic        pad_s, pad_f;
  logic        drive_on, want_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      lvl_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel) lvl_q <= wr_data[0];
      else        cfg_q <= wr_data;
    end
  end

  assign cfg    = pin_cfg_t'(cfg_q);
  assign cfg_rd = cfg_q;

  // Output path
  assign drive_on = cfg.enable & ~cfg.dir_in & (cfg.func == FUNC_GPIO);
  assign want_pad = lvl_q ^ ~cfg.act_high;

  always_comb begin
    if (cfg.open_drain) begin
      pad_out = 1'b0;
      pad_oe  = drive_on & ~want_pad;
    end else begin
      pad_out = want_pad;
      pad_oe  = drive_on;
    end
  end

  assign pad_pu = (cfg.pull == PULL_UP);
  assign pad_pd = (cfg.pull == PULL_DOWN);

  // Input path
  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
  );

  gpio_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw(pad_s), .level(pad_f)
  );

  assign lvl_rd_valid = cfg.enable &
                        ~(~cfg.dir_in & cfg.open_drain & (cfg.pull != PULL_UP));
  assign lvl_rd       = lvl_rd_valid & (pad_f ^ ~cfg.act_high);

  gpio_edge_irq u_irq (
    .clk(clk), .rst_n(rst_n), .level(pad_f), .arm(cfg.enable),
    .both(cfg.irq_both), .act_high(cfg.act_high), .clr(irq_clr), .flag(irq)
  );
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_rd,
  input logic        lvl_rd,
  input logic        lvl_rd_valid,
  input logic        pad_out,
  input logic        pad_oe,
  input logic        pad_pu,
  input logic        pad_pd,
  input logic        irq,
  input logic        irq_clr
);
  p_pull_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd));

  p_fn_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd[3:0] != 4'h0) |-> !pad_oe);

  p_od_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd[9] && pad_oe) |-> !pad_out);

  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[7] |-> (!pad_oe && !lvl_rd_valid));

  p_inv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_rd_valid |-> !lvl_rd);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .lvl_rd(lvl_rd),
  .lvl_rd_valid(lvl_rd_valid), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/tb_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_pin_ctrl;
  localparam int DEB = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, irq_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] cfg_rd;
  logic        lvl_rd, lvl_rd_valid, pad_out, pad_oe, pad_pu, pad_pd, irq;
  logic        ext = 1'b0;
  logic        pad_in;

  always #2 clk = ~clk;

  assign pad_in = pad_oe ? pad_out : (pad_pu ? 1'b1 : (pad_pd ? 1'b0 : ext));

  gpio_pin_ctrl #(.DEB_CYCLES(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_rd(cfg_rd), .lvl_rd(lvl_rd),
    .lvl_rd_valid(lvl_rd_valid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq),
    .irq_clr(irq_clr)
  );

  typedef struct {
    int          sig;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  localparam int S_CFG = 0, S_LVL = 1, S_VAL = 2, S_OUT = 3,
                 S_OE = 4, S_PU = 5, S_PD = 6, S_IRQ = 7;

  function automatic logic [15:0] observe(int s);
    case (s)
      S_CFG:   return cfg_rd;
      S_LVL:   return {15'd0, lvl_rd};
      S_VAL:   return {15'd0, lvl_rd_valid};
      S_OUT:   return {15'd0, pad_out};
      S_OE:    return {15'd0, pad_oe};
      S_PU:    return {15'd0, pad_pu};
      S_PD:    return {15'd0, pad_pd};
      default: return {15'd0, irq};
    endcase
  endfunction

  task automatic expect_sig(int s, logic [15:0] e, string r);
    item_t it;
    it.sig = s; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = observe(it.sig);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
  endtask

  task automatic flush();
    tick(1);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    expect_sig(S_CFG, 16'hA400, "R1"); expect_sig(S_OE, 0, "R1");
    expect_sig(S_PD, 1, "R1");         expect_sig(S_PU, 0, "R1");
    expect_sig(S_IRQ, 0, "R1");        expect_sig(S_VAL, 0, "R1");
    expect_sig(S_LVL, 0, "R1");
    flush();

    // Input, no pull, active-high, enabled
    wr(1'b0, 16'h8480);
    expect_sig(S_VAL, 1, "R8"); expect_sig(S_LVL, 0, "R8");
    expect_sig(S_PU, 0, "R3");  expect_sig(S_PD, 0, "R3");
    expect_sig(S_OE, 0, "R4");
    flush();

    // R7 short pulse ignored
    ext = 1'b1; tick(DEB - 1); ext = 1'b0; tick(10);
    expect_sig(S_LVL, 0, "R7 short pulse"); expect_sig(S_IRQ, 0, "R7 short pulse");
    flush();

    // R7 held level accepted, not before the window
    ext = 1'b1; tick(DEB);
    expect_sig(S_LVL, 0, "R7 early");
    flush();
    tick(4);
    expect_sig(S_LVL, 1, "R7 held");
    expect_sig(S_IRQ, 1, "R9 mode0 rise act-high");
    flush();

    clr_irq();
    expect_sig(S_IRQ, 0, "R10 clear");
    flush();
    ext = 1'b0; tick(DEB + 5);
    expect_sig(S_IRQ, 0, "R9 mode0 fall ignored when act-high");
    expect_sig(S_LVL, 0, "R8");
    flush();

    // Active-low
    wr(1'b0, 16'h8080);
    expect_sig(S_LVL, 1, "R8 inverted read");
    flush();
    ext = 1'b1; tick(DEB + 5);
    expect_sig(S_LVL, 0, "R8 inverted read");
    expect_sig(S_IRQ, 0, "R9 mode0 rise ignored when act-low");
    flush();
    ext = 1'b0; tick(DEB + 5);
    expect_sig(S_IRQ, 1, "R9 mode0 fall act-low");
    flush();

    // Mode 1, clear in the same cycle as an edge
    wr(1'b0, 16'h9080);
    clr_irq();
    ext = 1'b1;
    tick(DEB + 2);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    expect_sig(S_IRQ, 1, "R10 edge beats clear");
    flush();
    clr_irq();
    ext = 1'b0; tick(DEB + 5);
    expect_sig(S_IRQ, 1, "R9 mode1 fall");
    flush();

    // Disabled: no irq from edges
    wr(1'b0, 16'h9000);
    clr_irq();
    ext = 1'b1; tick(DEB + 5); ext = 1'b0; tick(DEB + 5);
    expect_sig(S_IRQ, 0, "R9 disabled");
    expect_sig(S_VAL, 0, "R6"); expect_sig(S_LVL, 0, "R6");
    flush();

    // Push-pull output
    wr(1'b0, 16'h0480);
    wr(1'b1, 16'hFFFF);
    expect_sig(S_OE, 1, "R4"); expect_sig(S_OUT, 1, "R4");
    flush();
    tick(DEB + 5);
    expect_sig(S_LVL, 1, "R8 output readback"); expect_sig(S_VAL, 1, "R8");
    flush();
    wr(1'b1, 16'h0000);
    expect_sig(S_OUT, 0, "R4 level 0");
    flush();
    wr(1'b0, 16'h0080);
    expect_sig(S_OUT, 1, "R4 inverted drive");
    flush();
    tick(DEB + 5);
    expect_sig(S_LVL, 0, "R8 inverted output readback");
    flush();
    wr(1'b0, 16'h0481);
    expect_sig(S_OE, 0, "R4 non-GPIO function");
    flush();

    // Open drain
    ext = 1'b1;
    wr(1'b0, 16'h0680);
    wr(1'b1, 16'h0001);
    expect_sig(S_OE, 0, "R5 release"); expect_sig(S_OUT, 0, "R5");
    expect_sig(S_VAL, 0, "R8 od no pull-up"); expect_sig(S_LVL, 0, "R8 od invalid");
    flush();
    wr(1'b1, 16'h0000);
    expect_sig(S_OE, 1, "R5 pull low"); expect_sig(S_OUT, 0, "R5");
    flush();
    wr(1'b0, 16'h4680);
    expect_sig(S_VAL, 1, "R8 od pull-up"); expect_sig(S_PU, 1, "R3");
    expect_sig(S_PD, 0, "R3");
    flush();
    wr(1'b0, 16'h6680);
    expect_sig(S_PU, 0, "R3 reserved"); expect_sig(S_PD, 0, "R3 reserved");
    flush();

    // Disabled output
    wr(1'b0, 16'h0400);
    expect_sig(S_OE, 0, "R6"); expect_sig(S_VAL, 0, "R6");
    flush();

    // Spare bits stored
    wr(1'b0, 16'h8C70);
    expect_sig(S_CFG, 16'h8C70, "R2");
    flush();
    wr(1'b1, 16'hFFFE);
    expect_sig(S_CFG, 16'h8C70, "R2 level write leaves config");
    flush();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule